// File: doc/BRIEF.md
# Variable-Width Sum-of-Products Array

This block is the programmable AND-OR plane of a ten-output programmable logic device. It takes twelve dedicated input signals and ten feedback signals from the output cells. Each signal appears in both true and complemented form, which gives 44 columns. A stored connection map says which columns feed each product-term row. The block evaluates every row at once. It then collects the rows into one group per output. The first row of a group becomes that output's three-state enable term, and the remaining rows are ORed into the output's sum term. Two more rows, outside any group, supply the global asynchronous-reset term and the synchronous-preset term.

Groups vary in size. The two outer outputs get the fewest rows and the two middle outputs get the most, which gives usable sum widths of 8 to 16 terms. The connection map is loaded one row word per clock through a shift chain before operation starts. Every output of the block is combinational in the pin, feedback and map state.

Top module: `sop_array`

## Requirements
- R1: While reset is low, and after it is released until a shift happens, every row connects all columns. As a result every enable, sum, reset and preset output reads 0 for any input.
- R2: Output k (0 to 9) owns 9+2*min(k,9-k) consecutive rows, and output 0's group starts at row 0. The groups occupy rows 0 to 129 in order of k, row 130 is the reset term and row 131 is the preset term.
- R3: On a clock edge with `cfg_shift` high, row r takes the old contents of row r-1 and row 0 takes `cfg_row`. As a result, after 132 shifts the first word shifted in sits in row 131. With `cfg_shift` low the map holds.
- R4: Bit 2s of a row word connects the true column of signal s and bit 2s+1 connects its complement. Signals 0 to 11 are `pin_in[0..11]` and signals 12 to 21 are `fb_in[0..9]`. A row is true when every connected column is 1.
- R5: A row with no connected column is always true.
- R6: A row that connects both the true and the complement column of one signal is always false.
- R7: `oe_term[k]` follows only the first row of group k. `sum_term[k]` is the OR of the other rows of group k and does not depend on the enable row.
- R8: `ar_term` follows only row 130 and `sp_term` follows only row 131. Neither one affects or is affected by any output group.
- R9: Feedback signals act as row inputs in the same way as the pin inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map shift chain |
| rst_n | input | 1 | Active-low reset; sets every map bit to 1 |
| cfg_shift | input | 1 | Shift enable for the map chain |
| cfg_row | input | 44 | Row word shifted into row 0 |
| pin_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals from the output cells |
| oe_term | output | 10 | Enable term per output |
| sum_term | output | 10 | OR of the non-enable rows per output |
| ar_term | output | 1 | Global asynchronous-reset product term |
| sp_term | output | 1 | Global synchronous-preset product term |

## Verification
The hold assertion assumes that pins and feedback only change between clock edges. It also assumes that the map changes only through the shift input. The bench therefore drives every input two time units after a rising edge and holds it across the next edge. The checks that look at the word just shifted into row 0 assume that reset stays high across that edge. The bench only asserts reset at the very start, before any shift.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_PIN    = 12,
  parameter int N_CELL   = 10,
  parameter int MIN_ROWS = 9,
  parameter int ROW_STEP = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_shift,
  input  logic [2*(N_PIN+N_CELL)-1:0]   cfg_row,
  input  logic [N_PIN-1:0]              pin_in,
  input  logic [N_CELL-1:0]             fb_in,
  output logic [N_CELL-1:0]             oe_term,
  output logic [N_CELL-1:0]             sum_term,
  output logic                          ar_term,
  output logic                          sp_term
);

  function automatic int grp_rows(int k);
    int d;
    d = (k < N_CELL - 1 - k) ? k : N_CELL - 1 - k;
    return MIN_ROWS + ROW_STEP * d;
  endfunction

  function automatic int grp_base(int k);
    int b;
    b = 0;
    for (int j = 0; j < k; j++) b += grp_rows(j);
    return b;
  endfunction

  localparam int N_SIG    = N_PIN + N_CELL;
  localparam int N_COL    = 2 * N_SIG;
  localparam int OUT_ROWS = grp_base(N_CELL);
  localparam int AR_ROW   = OUT_ROWS;
  localparam int SP_ROW   = OUT_ROWS + 1;
  localparam int N_ROWS   = OUT_ROWS + 2;

  logic [N_COL-1:0]  fuse [N_ROWS];
  logic [N_SIG-1:0]  sig;
  logic [N_COL-1:0]  col;
  logic [N_ROWS-1:0] row_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_ROWS; r++) fuse[r] <= '1;
    end else if (cfg_shift) begin
      fuse[0] <= cfg_row;
      for (int r = 1; r < N_ROWS; r++) fuse[r] <= fuse[r-1];
    end
  end

  assign sig = {fb_in, pin_in};

  genvar g;
  generate
    for (g = 0; g < N_SIG; g++) begin : g_col
      assign col[2*g]   = sig[g];
      assign col[2*g+1] = ~sig[g];
    end

    for (g = 0; g < N_ROWS; g++) begin : g_row
      assign row_hit[g] = &(~fuse[g] | col);
    end

    for (g = 0; g < N_CELL; g++) begin : g_cell
      localparam int BASE = grp_base(g);
      localparam int CNT  = grp_rows(g);
      assign oe_term[g]  = row_hit[BASE];
      assign sum_term[g] = |row_hit[BASE+CNT-1:BASE+1];
    end
  endgenerate

  assign ar_term = row_hit[AR_ROW];
  assign sp_term = row_hit[SP_ROW];

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_PIN  = 12,
  parameter int N_CELL = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_shift,
  input logic [2*(N_PIN+N_CELL)-1:0] cfg_row,
  input logic [N_PIN-1:0]            pin_in,
  input logic [N_CELL-1:0]           fb_in,
  input logic [N_CELL-1:0]           oe_term,
  input logic [N_CELL-1:0]           sum_term,
  input logic                        ar_term,
  input logic                        sp_term
);

  AST_RESET_ALL_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (oe_term == '0 && sum_term == '0 && !ar_term && !sp_term)); // R1

  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_shift) && $stable(pin_in) && $stable(fb_in))
    |-> ($stable(oe_term) && $stable(sum_term) && $stable(ar_term) && $stable(sp_term))); // R3

  AST_EMPTY_ROW_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_shift) && $past(cfg_row) == '0) |-> oe_term[0]); // R5

  AST_FULL_ROW_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_shift) && (&$past(cfg_row))) |-> !oe_term[0]); // R6

endmodule

bind sop_array sop_array_chk #(.N_PIN(N_PIN), .N_CELL(N_CELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_row(cfg_row),
  .pin_in(pin_in), .fb_in(fb_in), .oe_term(oe_term), .sum_term(sum_term),
  .ar_term(ar_term), .sp_term(sp_term)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int NR = 132;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_shift = 0;
  logic [43:0] cfg_row = '0;
  logic [11:0] pin_in = '0;
  logic [9:0]  fb_in = '0;
  logic [9:0]  oe_term, sum_term;
  logic        ar_term, sp_term;

  int checks = 0;
  int failures = 0;
  logic [43:0] map [NR];

  sop_array i_sop_array (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_row(cfg_row),
    .pin_in(pin_in), .fb_in(fb_in), .oe_term(oe_term), .sum_term(sum_term),
    .ar_term(ar_term), .sp_term(sp_term)
  );

  always #5 clk = ~clk;

  function automatic int rows_of(int k);
    return 9 + 2 * ((k < 9 - k) ? k : 9 - k);
  endfunction

  function automatic int base_of(int k);
    int b = 0;
    for (int j = 0; j < k; j++) b += rows_of(j);
    return b;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(logic [43:0] w);
    for (int i = 0; i < NR; i++) map[i] = w;
  endtask

  task automatic push_map();
    for (int i = NR - 1; i >= 0; i--) begin
      cfg_row = map[i];
      cfg_shift = 1;
      @(posedge clk); #2;
    end
    cfg_shift = 0;
  endtask

  task automatic t_reset();
    pin_in = 12'hA5C; fb_in = 10'h2F3; #1;
    chk("R1", "oe", oe_term, 0);  chk("R1", "sum", sum_term, 0);
    chk("R1", "ar", ar_term, 0);  chk("R1", "sp", sp_term, 0);
    pin_in = '0; fb_in = '0; #1;
    chk("R1", "sum zero inputs", sum_term, 0);
  endtask

  task automatic t_empty();
    fill('0); push_map(); #1;
    chk("R5", "oe all empty", oe_term, 10'h3FF);
    chk("R5", "sum all empty", sum_term, 10'h3FF);
    chk("R5", "ar/sp empty", {ar_term, sp_term}, 2'b11);
    @(posedge clk); #2; @(posedge clk); #2;
    chk("R3", "hold without shift", {oe_term, sum_term}, 20'hFFFFF);
  endtask

  task automatic t_order();
    fill('1); map[131] = '0; push_map(); #1;
    chk("R3", "first word lands in row 131", {ar_term, sp_term}, 2'b01);
    chk("R8", "preset isolated oe", oe_term, 0);
    chk("R8", "preset isolated sum", sum_term, 0);
    fill('1); map[130] = '0; push_map(); #1;
    chk("R8", "reset row only", {ar_term, sp_term}, 2'b10);
    cfg_row = '1; cfg_shift = 1; @(posedge clk); #2; cfg_shift = 0; #1;
    chk("R3", "one shift moves row 130 to 131", {ar_term, sp_term}, 2'b01);
  endtask

  task automatic t_product();
    int b4 = base_of(4);
    fill('1); map[b4] = '0; map[b4+1] = 44'h0 | (44'h1 << 0) | (44'h1 << 3);
    push_map();
    for (int v = 0; v < 4; v++) begin
      pin_in = 12'(v); #1;
      chk("R4", "sum4 = p0 & ~p1", {22'b0, sum_term}, {22'b0, 10'(((v & 1) && !(v & 2)) ? 10'h010 : 10'h0)});
    end
    chk("R7", "oe4 from enable row", oe_term, 10'h010);
    fill('1); map[b4 + rows_of(4) - 1] = 44'h1 << 0; push_map();
    pin_in = 12'h001; #1;
    chk("R2", "last row of group 4 feeds sum4", sum_term, 10'h010);
    pin_in = 12'h000; #1;
    chk("R4", "unmet true column", sum_term, 0);
  endtask

  task automatic t_conflict();
    fill('1); map[0] = 44'h3; map[1] = 44'h3; push_map();
    for (int v = 0; v < 2; v++) begin
      pin_in = 12'(v); #1;
      chk("R6", "true+comp row false", {oe_term[0], sum_term[0]}, 2'b00);
    end
  endtask

  task automatic t_feedback();
    fill('1); map[base_of(9) + 1] = 44'h1 << (2 * 21); push_map();
    pin_in = 12'hFFF;
    fb_in = 10'h200; #1; chk("R9", "fb9 high", sum_term, 10'h200);
    fb_in = 10'h1FF; #1; chk("R9", "fb9 low", sum_term, 10'h000);
    fb_in = '0;
  endtask

  task automatic t_groups();
    for (int k = 0; k < 10; k++) begin
      fill('1); map[base_of(k) + rows_of(k) - 1] = '0; push_map(); #1;
      chk("R2", $sformatf("last row group %0d", k), {oe_term, sum_term}, {10'h0, 10'(1 << k)});
      fill('1); map[base_of(k)] = '0; push_map(); #1;
      chk("R7", $sformatf("enable row group %0d", k), {oe_term, sum_term}, {10'(1 << k), 10'h0});
    end
  endtask

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_empty();
    t_order();
    t_product();
    t_conflict();
    t_feedback();
    t_groups();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule